// File: doc/BRIEF.md
# Post-Increment Load Sequencer

This block carries out a single three-byte load instruction that reads memory through a base register and then bumps that base register. After a start pulse it fetches the two low instruction bytes from the program counter. These hold the opcode and the two register indices. It then reads one data byte from memory at the address held in the base register and writes it to the destination register. Only after that does it fetch the third instruction byte, an unsigned increment, and write base + increment back to the base register. The load always uses the base value from before the increment.

Memory is byte wide and shared between instruction and data reads. Each read is a one-cycle request whose data comes back a fixed number of cycles later. The register file sits outside the block. The block reads it combinationally through an index and writes it through a synchronous write port.

The states, in order, are S_IDLE, S_FETCH_LO, S_WAIT_LO, S_FETCH_HI, S_WAIT_HI, S_LOAD_ADDR, S_LOAD_WAIT, S_WRITE_DST, S_FETCH_INC, S_WAIT_INC, S_ADD_BASE and S_DONE. The transitions are:
- S_IDLE moves on start.
- Each fetch state moves to its wait state.
- Each wait state leaves when the read latency expires.
- S_LOAD_ADDR goes to S_LOAD_WAIT when the opcode matches and to S_DONE when it does not.
- S_WRITE_DST goes to S_FETCH_INC.
- S_ADD_BASE goes to S_DONE.
- S_DONE returns to S_IDLE.

Top module: `postinc_load_seq`

## Requirements
- R1: After reset, busy, done, mem_rd and rf_we are low and next_pc is 0.
- R2: Instruction layout: byte 0 at entry_pc holds the opcode in bits 5:0 and destination index bits 1:0 in bits 7:6. Byte 1 at entry_pc+1 holds destination index bit 2 in bit 0 and the base index in bits 3:1. Byte 2 at entry_pc+2 is the increment. All addresses wrap modulo 256. After a matching instruction, next_pc equals entry_pc+3.
- R3: Each memory read is a mem_rd pulse of exactly one cycle. mem_rdata is taken 3 cycles after the request edge.
- R4: The destination register receives the memory byte at the base register's value from before the instruction.
- R5: The base register ends as its original value plus the increment. The increment is unsigned and the sum wraps modulo 256.
- R6: When destination and base indices are equal, the register ends holding original base + increment.
- R7: done is high for exactly one cycle, 18 cycles after the start edge. busy is high from that edge until done falls.
- R8: start while busy is ignored: entry_pc is not resampled and the instruction finishes unchanged.
- R9: Any opcode other than 6'b010000 causes no register write and no data read. done comes 9 cycles after start and next_pc equals entry_pc+2.
- R10: Registers other than the destination and base registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin one instruction at entry_pc |
| entry_pc | input | 8 | Address of instruction byte 0 |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| next_pc | output | 8 | Program counter after the bytes fetched |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 8 | Memory read address |
| mem_rdata | input | 8 | Memory data, valid 3 cycles after request |
| rf_raddr | output | 3 | Register read index (base register) |
| rf_rdata | input | 8 | Register read data |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 3 | Register write index |
| rf_wdata | output | 8 | Register write data |

## Verification
The hardest case to reach from the ports is telling the pre-increment address apart from the post-increment one. A memory image in which every byte differs from its neighbours makes a load from the wrong address produce a different value. The aliased case, where destination and base name one register, is driven directly: the only evidence of write ordering is which value survives. A second start pulse in the middle of a run is issued with a different entry address, so that any resampling would show up in next_pc and in the loaded values.

// File: rtl/plsq_pkg.sv
package plsq_pkg;
    localparam int REG_IDX_W = 3;
    localparam logic [5:0] OPC_LOAD_POSTINC = 6'b010000;

    typedef enum logic [3:0] {
        S_IDLE, S_FETCH_LO, S_WAIT_LO, S_FETCH_HI, S_WAIT_HI,
        S_LOAD_ADDR, S_LOAD_WAIT, S_WRITE_DST, S_FETCH_INC,
        S_WAIT_INC, S_ADD_BASE, S_DONE
    } state_e;
endpackage

// File: rtl/plsq_lat_timer.sv
module plsq_lat_timer #(
    parameter int LAT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic last
);
    localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;
    logic [CW-1:0] cnt;

    assign last = (cnt == CW'(LAT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (run && !last)
            cnt <= cnt + 1'b1;
    end

    // R3: the wait count never passes the read latency
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(LAT - 1));
endmodule

// File: rtl/plsq_instr_hold.sv
module plsq_instr_hold
    import plsq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_lo,
    input  logic                 ld_hi,
    input  logic                 ld_inc,
    input  logic [DATA_W-1:0]    din,
    output logic [5:0]           opcode,
    output logic [REG_IDX_W-1:0] dst_idx,
    output logic [REG_IDX_W-1:0] base_idx,
    output logic [DATA_W-1:0]    inc
);
    logic [7:0] lo_q;
    logic [3:0] hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
            inc  <= '0;
        end else begin
            if (ld_lo)  lo_q <= din[7:0];
            if (ld_hi)  hi_q <= din[3:0];
            if (ld_inc) inc  <= din;
        end
    end

    assign opcode   = lo_q[5:0];
    assign dst_idx  = {hi_q[0], lo_q[7:6]};
    assign base_idx = hi_q[3:1];
endmodule

// File: rtl/postinc_load_seq.sv
module postinc_load_seq
    import plsq_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int MEM_LAT = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [DATA_W-1:0]    entry_pc,
    output logic                 busy,
    output logic                 done,
    output logic [DATA_W-1:0]    next_pc,
    output logic                 mem_rd,
    output logic [DATA_W-1:0]    mem_addr,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic [REG_IDX_W-1:0] rf_raddr,
    input  logic [DATA_W-1:0]    rf_rdata,
    output logic                 rf_we,
    output logic [REG_IDX_W-1:0] rf_waddr,
    output logic [DATA_W-1:0]    rf_wdata
);
    state_e state, state_nx;

    logic [DATA_W-1:0]    pc_q, base_q, data_q, inc;
    logic [5:0]           opcode;
    logic [REG_IDX_W-1:0] dst_idx, base_idx;
    logic                 wait_run, wait_last, wait_done, op_ok;

    assign op_ok     = (opcode == OPC_LOAD_POSTINC);
    assign wait_run  = (state == S_WAIT_LO) || (state == S_WAIT_HI) ||
                       (state == S_LOAD_WAIT) || (state == S_WAIT_INC);
    assign wait_done = wait_run && wait_last;

    plsq_lat_timer #(.LAT(MEM_LAT)) u_timer (
        .clk(clk), .rst_n(rst_n), .clear(mem_rd), .run(wait_run), .last(wait_last)
    );

    plsq_instr_hold #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n),
        .ld_lo(state == S_WAIT_LO && wait_done),
        .ld_hi(state == S_WAIT_HI && wait_done),
        .ld_inc(state == S_WAIT_INC && wait_done),
        .din(mem_rdata),
        .opcode(opcode), .dst_idx(dst_idx), .base_idx(base_idx), .inc(inc)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:      if (start) state_nx = S_FETCH_LO;
            S_FETCH_LO:  state_nx = S_WAIT_LO;
            S_WAIT_LO:   if (wait_done) state_nx = S_FETCH_HI;
            S_FETCH_HI:  state_nx = S_WAIT_HI;
            S_WAIT_HI:   if (wait_done) state_nx = S_LOAD_ADDR;
            S_LOAD_ADDR: state_nx = op_ok ? S_LOAD_WAIT : S_DONE;
            S_LOAD_WAIT: if (wait_done) state_nx = S_WRITE_DST;
            S_WRITE_DST: state_nx = S_FETCH_INC;
            S_FETCH_INC: state_nx = S_WAIT_INC;
            S_WAIT_INC:  if (wait_done) state_nx = S_ADD_BASE;
            S_ADD_BASE:  state_nx = S_DONE;
            S_DONE:      state_nx = S_IDLE;
            default:     state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_rd   = 1'b0;
        mem_addr = pc_q;
        rf_we    = 1'b0;
        rf_waddr = base_idx;
        rf_wdata = base_q + inc;
        unique case (state)
            S_FETCH_LO, S_FETCH_HI, S_FETCH_INC: mem_rd = 1'b1;
            S_LOAD_ADDR: begin
                mem_rd   = op_ok;
                mem_addr = rf_rdata;
            end
            S_WRITE_DST: begin
                rf_we    = 1'b1;
                rf_waddr = dst_idx;
                rf_wdata = data_q;
            end
            S_ADD_BASE: rf_we = 1'b1;
            default: ;
        endcase
    end

    assign rf_raddr = base_idx;
    assign busy     = (state != S_IDLE);
    assign done     = (state == S_DONE);
    assign next_pc  = pc_q;

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q   <= '0;
            base_q <= '0;
            data_q <= '0;
        end else begin
            if (state == S_IDLE && start)
                pc_q <= entry_pc;
            else if (state == S_FETCH_LO || state == S_FETCH_HI || state == S_FETCH_INC)
                pc_q <= pc_q + 1'b1;
            if (state == S_LOAD_ADDR)
                base_q <= rf_rdata;
            if (state == S_LOAD_WAIT && wait_done)
                data_q <= mem_rdata;
        end
    end

    // R7: done lasts one cycle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7: done follows the final register write, or the opcode rejection
    p_done_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(rf_we) || $past(state == S_LOAD_ADDR)));
    // R3: each read request is a single-cycle pulse
    p_rd_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);
    // R2: every instruction byte fetch moves the program counter by one
    p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && state != S_LOAD_ADDR) |=> (pc_q == $past(pc_q) + 1'b1));
    // R4: the captured base address is held until the increment is written
    p_base_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {S_WRITE_DST, S_FETCH_INC, S_WAIT_INC, S_ADD_BASE}) |-> $stable(base_q));
    // R8: while busy and not finishing, the unit does not return to idle
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

// File: tb/sim_postinc_load_seq.sv
module sim_postinc_load_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] entry_pc = '0;
    logic       busy, done, mem_rd, rf_we;
    logic [7:0] next_pc, mem_addr, mem_rdata, rf_rdata, rf_wdata;
    logic [2:0] rf_raddr, rf_waddr;

    int errors = 0;
    int checks = 0;
    int rd_cnt = 0;
    int we_cnt = 0;
    bit finished = 1'b0;

    logic [7:0] mem [256];
    logic [7:0] rf [8];
    logic [7:0] p1, p2, p3;

    always #4 clk = ~clk;

    postinc_load_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .entry_pc(entry_pc),
        .busy(busy), .done(done), .next_pc(next_pc),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
    );

    // memory with 3-cycle read latency, register file with sync write
    always @(posedge clk) begin
        p1 <= mem[mem_addr];
        p2 <= p1;
        p3 <= p2;
        if (rf_we) rf[rf_waddr] <= rf_wdata;
        if (mem_rd) rd_cnt = rd_cnt + 1;
        if (rf_we)  we_cnt = we_cnt + 1;
    end
    assign mem_rdata = p3;
    assign rf_rdata  = rf[rf_raddr];

    // {pc, dst, base, base value, increment}
    localparam logic [39:0] VEC [0:4] = '{
        40'h00_01_02_40_01,
        40'h10_07_00_80_10,
        40'h20_03_05_F8_10,
        40'h30_04_04_60_05,
        40'hFE_02_06_90_FF
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic fill_mem();
        for (int a = 0; a < 256; a++) mem[a] = 8'(a * 3 + 8'h17);
        for (int k = 0; k < 8; k++) rf[k] = 8'hA0 + 8'(k);
    endtask

    task automatic run_instr(input logic [7:0] pc, input logic [5:0] op,
                             input logic [2:0] dst, input logic [2:0] base,
                             input logic [7:0] incv, input bit poke,
                             output int lat, output bit busy_ok);
        logic [7:0] a;
        a = pc;          mem[a] = {dst[1:0], op};
        a = pc + 8'd1;   mem[a] = {4'b0000, base, dst[2]};
        a = pc + 8'd2;   mem[a] = incv;
        @(negedge clk);
        rd_cnt = 0; we_cnt = 0;
        entry_pc = pc; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0; entry_pc = 8'h00;
        lat = 0; busy_ok = 1'b1;
        while (!done && lat < 100) begin
            if (!busy) busy_ok = 1'b0;
            if (poke && lat == 5) begin start = 1'b1; entry_pc = 8'hAA; end
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            lat++;
        end
        if (!busy) busy_ok = 1'b0;
    endtask

    task automatic do_vec(input logic [7:0] pc, input logic [2:0] dst,
                          input logic [2:0] base, input logic [7:0] bval,
                          input logic [7:0] incv, input bit poke);
        logic [7:0] snap [8];
        logic [7:0] exp_ld, exp_base;
        int lat; bit bok;
        fill_mem();
        rf[base] = bval;
        for (int k = 0; k < 8; k++) snap[k] = rf[k];
        exp_ld   = mem[bval];
        exp_base = bval + incv;
        run_instr(pc, 6'b010000, dst, base, incv, poke, lat, bok);
        chk("R7 done latency", 32'(lat), 32'd18);
        chk("R7 busy until done", 32'(bok), 32'd1);
        chk("R3 read count", 32'(rd_cnt), 32'd4);
        @(negedge clk);
        chk("R7 done single cycle", 32'(done), 32'd0);
        chk("R7 busy drops", 32'(busy), 32'd0);
        chk("R2 next_pc", 32'(next_pc), 32'(8'(pc + 8'd3)));
        if (dst == base)
            chk("R6 alias keeps increment", 32'(rf[base]), 32'(exp_base));
        else begin
            chk("R4 load from pre-increment base", 32'(rf[dst]), 32'(exp_ld));
            chk("R5 base incremented", 32'(rf[base]), 32'(exp_base));
        end
        for (int k = 0; k < 8; k++)
            if (k != int'(dst) && k != int'(base))
                chk("R10 other register kept", 32'(rf[k]), 32'(snap[k]));
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int lat; bit bok;
        logic [7:0] snap [8];
        fill_mem();
        repeat (3) @(negedge clk);
        chk("R1 busy at reset", 32'(busy), 32'd0);
        chk("R1 done at reset", 32'(done), 32'd0);
        chk("R1 mem_rd at reset", 32'(mem_rd), 32'd0);
        chk("R1 rf_we at reset", 32'(rf_we), 32'd0);
        chk("R1 next_pc at reset", 32'(next_pc), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R4 R5 R6 R10: table of vectors
        for (int v = 0; v < 5; v++)
            do_vec(VEC[v][39:32], VEC[v][26:24], VEC[v][18:16], VEC[v][15:8], VEC[v][7:0], 1'b0);

        // R5: zero increment leaves base unchanged
        do_vec(8'h40, 3'd5, 3'd6, 8'h33, 8'h00, 1'b0);

        // R8: second start mid-run with another entry address
        do_vec(8'h50, 3'd1, 3'd3, 8'h70, 8'h22, 1'b1);

        // R9: foreign opcode
        fill_mem();
        for (int k = 0; k < 8; k++) snap[k] = rf[k];
        run_instr(8'h60, 6'b010001, 3'd2, 3'd4, 8'h09, 1'b0, lat, bok);
        chk("R9 reject latency", 32'(lat), 32'd9);
        chk("R9 no register write", 32'(we_cnt), 32'd0);
        chk("R9 no data read", 32'(rd_cnt), 32'd2);
        @(negedge clk);
        chk("R9 next_pc", 32'(next_pc), 32'h62);
        for (int k = 0; k < 8; k++)
            chk("R9 registers unchanged", 32'(rf[k]), 32'(snap[k]));

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule